// File: doc/BRIEF.md
# Packed Lane Shifter

The block takes a 64-bit operand and moves bits inside lanes of 16, 32 or 64 bits. Logical right, logical left, arithmetic right and rotate right each act on every lane on its own, so no bit ever crosses from one lane into its neighbour. A fifth operation rearranges the four halfwords of the operand under an 8-bit selector. With each result the block produces a 32-bit flag word that holds a negative (N) bit and a zero (Z) bit for every lane.

A caller presents the operand, a 6-bit count, the lane size, the operation code and the selector together with a one-cycle `start` pulse. On the next clock edge the result and flags are registered and `valid` is high for one cycle. Requests may be issued on every cycle. Between requests the outputs keep their last values.

Top module: `lane_shift_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `result`, `flags` and `valid` are zero until the first request.
- R2: `valid` is high in exactly the cycle after each cycle in which `start` is high. `result` and `flags` change only on a clock edge at which `start` is high, and otherwise keep their values.
- R3: Lane size codes are 0 for 16-bit lanes, 1 for 32-bit lanes, and 2 or 3 for one 64-bit lane. Operation 0 is a logical right shift and operation 1 is a logical left shift, each by `count` within every lane. Vacated bits are zero, and a count equal to or above the lane width gives a zero lane.
- R4: Operation 2 is an arithmetic right shift within every lane. It fills from that lane's own top bit (bit 63 for the 64-bit lane), and a count at or above the lane width fills the lane with its sign.
- R5: Operation 3 rotates every lane right by `count` modulo the lane width. Bits that leave the bottom of a lane re-enter at the top of the same lane, and a count of zero returns the operand unchanged.
- R6: Operation 4 sets output halfword k (bits 16k+15..16k) to input halfword `shuf_ctl[2k+1:2k]`, whatever the lane size and count.
- R7: `flags` holds N (the lane's top result bit) and Z (set when the lane is all zero) for each lane. For a 16-bit lane i, N is at bit 8i+7 and Z at bit 8i+6. For a 32-bit lane i, N is at bit 16i+15 and Z at bit 16i+14. For the 64-bit lane, N is at bit 31 and Z at bit 30. Operation 4 always uses the 16-bit layout, and all other flag bits are zero.
- R8: Operation codes 5, 6 and 7 return the operand unchanged, with flags laid out for the selected lane size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| lane | input | 2 | Lane size code |
| count | input | 6 | Shift or rotate amount |
| shuf_ctl | input | 8 | Halfword selector for operation 4 |
| operand | input | 64 | Data in |
| result | output | 64 | Registered result |
| flags | output | 32 | Registered per-lane N and Z bits |
| valid | output | 1 | High one cycle after each request |

## Verification
The capture of a new request and the presentation of the previous result can fall in the same cycle. This happens when requests arrive back to back: `valid` stays high while `result` already holds the next answer. The bench provokes this by issuing the whole count sweep with no idle cycles between requests. Its scoreboard pops one expected item per `valid` cycle, so an extra, missing or stale output shows up as a mismatch. Separate idle stretches with changing inputs confirm that nothing moves without `start`.

// File: rtl/lane_shift_unit.sv
module lane_shift_unit #(
  parameter int DW = 64,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [1:0]    lane,
  input  logic [CW-1:0] count,
  input  logic [7:0]    shuf_ctl,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] result,
  output logic [DW/2-1:0] flags,
  output logic          valid
);
  localparam int NSZ = 3;
  localparam int FW  = DW / 2;
  localparam logic [2:0] OP_SRL = 3'd0;
  localparam logic [2:0] OP_SLL = 3'd1;
  localparam logic [2:0] OP_SRA = 3'd2;
  localparam logic [2:0] OP_ROR = 3'd3;
  localparam logic [2:0] OP_SHF = 3'd4;

  logic [NSZ-1:0][DW-1:0] by_size;
  logic [NSZ-1:0][FW-1:0] flag_by_size;
  logic [DW-1:0]          shuf;
  logic [DW-1:0]          nxt;
  logic [1:0]             sz, fsz;

  for (genvar g = 0; g < NSZ; g++) begin : g_size
    localparam int W  = 16 << g;
    localparam int NL = DW / W;
    localparam int RW = $clog2(W);
    for (genvar j = 0; j < NL; j++) begin : g_lane
      logic [W-1:0]   x;
      logic [2*W-1:0] dbl;
      logic           over;
      assign x    = operand[j*W +: W];
      assign over = int'(count) >= W;
      assign dbl  = {x, x} >> count[RW-1:0];
      assign by_size[g][j*W +: W] =
          (op == OP_SRL) ? (over ? '0 : x >> count) :
          (op == OP_SLL) ? (over ? '0 : x << count) :
          (op == OP_SRA) ? W'($signed(x) >>> count) :
          (op == OP_ROR) ? dbl[W-1:0] : x;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_shuf
    assign shuf[16*k +: 16] = operand[{shuf_ctl[2*k +: 2], 4'b0} +: 16];
  end

  assign sz  = (lane == 2'd0) ? 2'd0 : (lane == 2'd1) ? 2'd1 : 2'd2;
  assign fsz = (op == OP_SHF) ? 2'd0 : sz;
  assign nxt = (op == OP_SHF) ? shuf : by_size[sz];

  for (genvar g = 0; g < NSZ; g++) begin : g_flag
    localparam int W  = 16 << g;
    localparam int NL = DW / W;
    localparam int F  = FW / NL;
    for (genvar j = 0; j < NL; j++) begin : g_lane
      assign flag_by_size[g][j*F +: F] =
          {nxt[j*W + W - 1], nxt[j*W +: W] == '0, {(F-2){1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      flags  <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= start;
      if (start) begin
        result <= nxt;
        flags  <= flag_by_size[fsz];
      end
    end
  end

  a_r2_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);
  a_r2_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid);
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(flags)));
  a_r3_srl_overrun_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_SRL && lane == 2'd0 && count >= 6'd16) |=> (result == '0));
  a_r5_rotate_zero_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_ROR && count == '0) |=> (result == $past(operand)));
  a_r6_shuffle_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_SHF && shuf_ctl == 8'hE4) |=> (result == $past(operand)));
  a_r7_flag_layout: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (((flags & {flags[FW-2:0], 1'b0} & 32'h8080_8080) == '0) &&
               ((flags & 32'h3F3F_3F3F) == '0)));
endmodule

// File: tb/lane_shift_unit_bench.sv
`timescale 1ns/1ps
module lane_shift_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  lane = '0;
  logic [5:0]  count = '0;
  logic [7:0]  shuf_ctl = '0;
  logic [63:0] operand = '0;
  logic [63:0] result;
  logic [31:0] flags;
  logic        valid;

  int nchk = 0;
  int nfail = 0;
  logic [63:0] seed = 64'h0123_4567_89AB_CDEF;

  typedef struct {
    logic [63:0] r;
    logic [31:0] f;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  lane_shift_unit u_lane_shift_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .lane(lane),
    .count(count), .shuf_ctl(shuf_ctl), .operand(operand),
    .result(result), .flags(flags), .valid(valid));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed;
  endfunction

  function automatic void model(input logic [2:0] o, input logic [1:0] ln,
      input logic [5:0] c, input logic [7:0] ctl, input logic [63:0] x,
      output logic [63:0] r, output logic [31:0] f);
    int w, nl, fw, ci;
    logic z;
    r = '0; f = '0; ci = int'(c);
    if (o == 3'd4) begin
      for (int k = 0; k < 4; k++)
        for (int b = 0; b < 16; b++) r[16*k+b] = x[16*int'(ctl[2*k +: 2])+b];
      w = 16;
    end else begin
      w = (ln == 2'd0) ? 16 : (ln == 2'd1) ? 32 : 64;
      for (int base = 0; base < 64; base += w)
        for (int b = 0; b < w; b++)
          case (o)
            3'd0: r[base+b] = (b + ci < w) ? x[base+b+ci] : 1'b0;
            3'd1: r[base+b] = (b >= ci) ? x[base+b-ci] : 1'b0;
            3'd2: r[base+b] = (b + ci < w) ? x[base+b+ci] : x[base+w-1];
            3'd3: r[base+b] = x[base + ((b + ci) % w)];
            default: r[base+b] = x[base+b];
          endcase
    end
    nl = 64 / w; fw = 32 / nl;
    for (int l = 0; l < nl; l++) begin
      z = 1'b1;
      for (int b = 0; b < w; b++) if (r[l*w+b]) z = 1'b0;
      f[l*fw+fw-1] = r[l*w+w-1];
      f[l*fw+fw-2] = z;
    end
  endfunction

  task automatic issue(logic [2:0] o, logic [1:0] ln, logic [5:0] c,
                       logic [7:0] ctl, logic [63:0] x);
    exp_t e;
    @(negedge clk);
    op = o; lane = ln; count = c; shuf_ctl = ctl; operand = x; start = 1'b1;
    model(o, ln, c, ctl, x, e.r, e.f);
    e.tag = (o == 3'd0 || o == 3'd1) ? "R3" : (o == 3'd2) ? "R4" :
            (o == 3'd3) ? "R5" : (o == 3'd4) ? "R6" : "R8";
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (q.size() == 0) check("R2 valid without request", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, result, e.r);
        check("R7", {32'd0, flags}, {32'd0, e.f});
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [63:0] held_r;
    logic [31:0] held_f;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 result", result, 64'd0);
    check("R1 flags", {32'd0, flags}, 64'd0);
    check("R1 valid", {63'd0, valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", result, 64'd0);

    // Back-to-back sweep of every count, operation and lane size
    for (int o = 0; o < 4; o++)
      for (int ln = 0; ln < 4; ln++)
        for (int c = 0; c < 64; c++)
          issue(3'(o), 2'(ln), 6'(c), 8'h00, rnd());
    // Sign-heavy and zero operands (R4, R7)
    for (int ln = 0; ln < 3; ln++) begin
      issue(3'd2, 2'(ln), 6'd63, 8'h00, 64'h8000_7FFF_8001_0000);
      issue(3'd2, 2'(ln), 6'd16, 8'h00, 64'hF0F0_0F0F_8000_7FFF);
      issue(3'd0, 2'(ln), 6'd0, 8'h00, 64'd0);
      issue(3'd3, 2'(ln), 6'd1, 8'h00, 64'h0001_0001_0001_0001);
    end
    // R6 every selector, with lane and count varied
    for (int s = 0; s < 256; s++)
      issue(3'd4, 2'(s % 4), 6'(s), 8'(s), rnd());
    // R8 reserved codes
    for (int o = 5; o < 8; o++)
      for (int ln = 0; ln < 4; ln++)
        issue(3'(o), 2'(ln), 6'd7, 8'h1B, rnd());
    idle(3);

    // R2 hold while idle with changing inputs
    issue(3'd1, 2'd0, 6'd3, 8'h00, 64'h1234_5678_9ABC_DEF0);
    idle(2);
    held_r = result; held_f = flags;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      op = 3'(i); count = 6'(i * 9); operand = rnd(); lane = 2'(i);
      @(negedge clk);
      check("R2 result hold", result, held_r);
      check("R2 flags hold", {32'd0, flags}, {32'd0, held_f});
      check("R2 valid low", {63'd0, valid}, 64'd0);
    end
    idle(2);
    check("R2 queue drained", 64'(q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule